// File: doc/BRIEF.md
# Rename Stage Stall Controller

This block is the control state machine of a register-rename pipeline stage. Each cycle it decides whether the stage renames instructions, holds, drains held work, or discards work after a pipeline flush. Decode delivers one group of up to `WIDTH` instructions per cycle. A group that cannot be handled is parked in a small skid queue of whole groups. While the stage is not ready for new groups, the controller raises a stall toward decode.

The controller takes stall requests from the execute and commit stages, and flush requests from commit. Commit can flush in two ways: a single-cycle flush and a continuing flush of the reorder buffer. It also receives reported free counts for the reorder buffer, the issue queue and the physical registers. The reorder-buffer and issue-queue counts are discounted by `WIDTH * FB_DELAY`, because up to that many instructions may already be on the way that the counts do not yet reflect.

The main output is the number of instructions the rename datapath may process in the current cycle. It comes with the source of those instructions (the arriving decode group or the skid-queue head) and the position inside that group at which to start. When a group is only partly renamed, the start position is kept so that the next attempt continues from the first instruction not yet processed.

Top module: `rename_stall_ctrl`

## Requirements
- R1: While reset is low and right after it is released, `st_o` is 0 (Running), `stall_up` is 0, `skid_level` is 0 and `rn_cnt` is 0. The state code is 0 for Running, 1 for Blocked, 2 for Unblocking and 3 for Squashing.
- R2: In Running or Unblocking with no flush request, if `exe_stall` or `cmt_stall` is high, then the following happens in that cycle: nothing is renamed, `stall_up` is 1, and a group with a non-zero `dec_cnt` is appended to the skid queue. The next state is Blocked.
- R3: In Blocked, `stall_up` is 1 and `rn_cnt` is 0 in every cycle, and every group with a non-zero `dec_cnt` is appended to the skid queue. Groups of size zero are never queued.
- R4: Blocked is left without a flush only when all of the following hold: both stall inputs are low, usable reorder-buffer credit is above zero, usable issue-queue credit is above zero, and `preg_free` is non-zero. The next state is then Unblocking, or Running if the queue is empty and no group arrives in that cycle.
- R5: Usable reorder-buffer credit is `rob_free - WIDTH*FB_DELAY`, and usable issue-queue credit is `iq_free - WIDTH*FB_DELAY`, both taken as signed values. In Running, if the smaller of the two is at least `dec_cnt`, the whole group is renamed (`rn_cnt = dec_cnt`, `rn_from_skid = 0`, `rn_start = 0`) and the stage stays in Running.
- R6: If the smaller usable credit is positive but below the number of instructions available, exactly that many are renamed. The stage then goes to Blocked with `stall_up` at 1, and a non-zero arriving group is queued.
- R7: If the smaller usable credit is zero or negative while there is work to do, nothing is renamed, `stall_up` is 1 and the next state is Blocked.
- R8: In Unblocking, instructions come from the skid-queue head (`rn_from_skid = 1`). When the rest of the head group fits in the credit, the head is removed. `stall_up` stays 1 until that removal leaves the queue empty, and at that point the state returns to Running with `stall_up` at 0.
- R9: After a partial rename, the count renamed is added to the start position. The next rename of that group begins there (`rn_start`), and `rn_cnt` then covers only the remaining instructions. The position returns to 0 once a group is finished.
- R10: A high `cmt_squash` or `cmt_rob_squash` in any state makes the next state Squashing. It also empties the skid queue and clears the start position. While a flush request is high in Squashing, nothing is renamed and `stall_up` is 0.
- R11: In Squashing, once both flush inputs are low, the stage behaves as Running in that same cycle: it renames the arriving group under the usual credit and stall rules.
- R12: In Running, a group with `dec_cnt` of 0 with no flush or stall request produces no rename and no stall, and the state stays Running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_cnt | input | CNT_W | Size of the group arriving from decode this cycle |
| exe_stall | input | 1 | Stall request from execute |
| cmt_stall | input | 1 | Stall request from commit |
| cmt_squash | input | 1 | Single-cycle flush request from commit |
| cmt_rob_squash | input | 1 | Continuing reorder-buffer flush from commit |
| rob_free | input | CRD_W | Reported free reorder-buffer entries |
| iq_free | input | CRD_W | Reported free issue-queue entries |
| preg_free | input | CRD_W | Reported free physical registers |
| rn_cnt | output | CNT_W | Instructions to rename this cycle |
| rn_from_skid | output | 1 | Instructions come from the skid-queue head |
| rn_start | output | CNT_W | Position in the group of the first instruction to rename |
| stall_up | output | 1 | Stall toward decode |
| st_o | output | 2 | Current state code |
| skid_level | output | LVL_W | Groups held in the skid queue |

## Verification
`rn_cnt`, `rn_from_skid`, `rn_start` and `stall_up` are combinational, so they are due in the same cycle as the inputs that cause them. `st_o` and `skid_level` change one rising edge later. The bench therefore drives inputs on the falling edge and compares all outputs 1 ns later. It advances its reference model only at the following rising edge, so every state or queue effect is checked in the cycle after its cause. The sweeps run three input mixes (loose credits, tight credits, heavy flushing). The reference model records which requirement each cycle exercises, and a final check confirms that every requirement was reached.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [1:0] {
    RSC_RUN = 2'd0,
    RSC_BLK = 2'd1,
    RSC_UNB = 2'd2,
    RSC_SQ  = 2'd3
  } rsc_state_e;
endpackage

// File: rtl/rsc_skid_fifo.sv
module rsc_skid_fifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 3,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] head,
  output logic [LW-1:0] level
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q, rd_nx, wr_nx;
  logic [LW-1:0] lvl_q, lvl_nx;
  logic          do_push, do_pop, ptr_en;

  always_comb begin
    do_pop  = pop && (lvl_q != '0);
    do_push = push && ((lvl_q != LW'(DEPTH)) || do_pop);
    rd_nx   = rd_q;
    wr_nx   = wr_q;
    lvl_nx  = lvl_q;
    if (flush) begin
      rd_nx  = '0;
      wr_nx  = '0;
      lvl_nx = '0;
    end else begin
      if (do_pop)
        rd_nx = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      if (do_push)
        wr_nx = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      lvl_nx = lvl_q + LW'(do_push) - LW'(do_pop);
    end
    ptr_en = flush || do_push || do_pop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      lvl_q <= '0;
    end else if (ptr_en) begin
      rd_q  <= rd_nx;
      wr_q  <= wr_nx;
      lvl_q <= lvl_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush)
      mem_q[wr_q] <= wdata;
  end

  assign head  = mem_q[rd_q];
  assign level = lvl_q;
endmodule

// File: rtl/rsc_credit.sv
module rsc_credit #(
  parameter int WIDTH    = 4,
  parameter int FB_DELAY = 1,
  parameter int CRD_W    = 6,
  parameter int CNT_W    = 3
) (
  input  logic [CRD_W-1:0] rob_free,
  input  logic [CRD_W-1:0] iq_free,
  input  logic [CRD_W-1:0] preg_free,
  output logic [CNT_W-1:0] cap,
  output logic             cap_none,
  output logic             room_ok
);
  localparam int SW  = CRD_W + 2;
  localparam int PEN = WIDTH * FB_DELAY;

  logic signed [SW-1:0] rob_adj, iq_adj, lim;
  logic                 rob_pos, iq_pos;

  always_comb begin
    rob_adj  = $signed({2'b00, rob_free}) - $signed(SW'(PEN));
    iq_adj   = $signed({2'b00, iq_free}) - $signed(SW'(PEN));
    lim      = (rob_adj < iq_adj) ? rob_adj : iq_adj;
    cap_none = lim[SW-1] || (lim == '0);
    if (cap_none)
      cap = '0;
    else if (lim > $signed(SW'(WIDTH)))
      cap = CNT_W'(WIDTH);
    else
      cap = lim[CNT_W-1:0];
    rob_pos = !rob_adj[SW-1] && (rob_adj != '0);
    iq_pos  = !iq_adj[SW-1] && (iq_adj != '0);
    room_ok = rob_pos && iq_pos && (preg_free != '0);
  end
endmodule

// File: rtl/rename_stall_ctrl.sv
module rename_stall_ctrl #(
  parameter int WIDTH      = 4,
  parameter int FB_DELAY   = 1,
  parameter int SKID_DEPTH = 4,
  parameter int CRD_W      = 6,
  parameter int CNT_W      = $clog2(WIDTH + 1),
  parameter int LVL_W      = $clog2(SKID_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] dec_cnt,
  input  logic             exe_stall,
  input  logic             cmt_stall,
  input  logic             cmt_squash,
  input  logic             cmt_rob_squash,
  input  logic [CRD_W-1:0] rob_free,
  input  logic [CRD_W-1:0] iq_free,
  input  logic [CRD_W-1:0] preg_free,
  output logic [CNT_W-1:0] rn_cnt,
  output logic             rn_from_skid,
  output logic [CNT_W-1:0] rn_start,
  output logic             stall_up,
  output logic [1:0]       st_o,
  output logic [LVL_W-1:0] skid_level
);
  import rsc_pkg::*;

  rsc_state_e       st_q, st_nx;
  logic [CNT_W-1:0] idx_q, idx_nx, head_cnt, cap, avail;
  logic             idx_en, cap_none, room_ok;
  logic             push, pop, flush, squash_any, dec_nz, stall_in, run_mode;

  rsc_skid_fifo #(
    .DEPTH (SKID_DEPTH),
    .DW    (CNT_W),
    .LW    (LVL_W)
  ) u_skid (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .flush (flush),
    .wdata (dec_cnt),
    .head  (head_cnt),
    .level (skid_level)
  );

  rsc_credit #(
    .WIDTH    (WIDTH),
    .FB_DELAY (FB_DELAY),
    .CRD_W    (CRD_W),
    .CNT_W    (CNT_W)
  ) u_credit (
    .rob_free  (rob_free),
    .iq_free   (iq_free),
    .preg_free (preg_free),
    .cap       (cap),
    .cap_none  (cap_none),
    .room_ok   (room_ok)
  );

  always_comb begin
    squash_any   = cmt_squash || cmt_rob_squash;
    dec_nz       = (dec_cnt != '0);
    stall_in     = exe_stall || cmt_stall;
    run_mode     = (st_q != RSC_UNB);
    avail        = run_mode ? dec_cnt : (head_cnt - idx_q);
    st_nx        = st_q;
    idx_nx       = idx_q;
    idx_en       = 1'b0;
    push         = 1'b0;
    pop          = 1'b0;
    flush        = 1'b0;
    stall_up     = 1'b0;
    rn_cnt       = '0;
    rn_from_skid = 1'b0;
    rn_start     = '0;

    if (st_q == RSC_SQ && squash_any) begin
      flush  = 1'b1;
      idx_nx = '0;
      idx_en = 1'b1;
    end else if (st_q == RSC_BLK) begin
      stall_up = 1'b1;
      if (squash_any) begin
        st_nx  = RSC_SQ;
        flush  = 1'b1;
        idx_nx = '0;
        idx_en = 1'b1;
      end else begin
        push = dec_nz;
        if (!stall_in && room_ok)
          st_nx = (skid_level == '0 && !dec_nz) ? RSC_RUN : RSC_UNB;
      end
    end else if (squash_any) begin
      st_nx  = RSC_SQ;
      flush  = 1'b1;
      idx_nx = '0;
      idx_en = 1'b1;
    end else if (stall_in) begin
      st_nx    = RSC_BLK;
      push     = dec_nz;
      stall_up = 1'b1;
    end else if (run_mode && !dec_nz) begin
      st_nx = RSC_RUN;
    end else if (cap_none) begin
      st_nx    = RSC_BLK;
      push     = dec_nz;
      stall_up = 1'b1;
    end else if (cap < avail) begin
      rn_cnt       = cap;
      rn_from_skid = !run_mode;
      rn_start     = run_mode ? '0 : idx_q;
      idx_nx       = idx_q + cap;
      idx_en       = 1'b1;
      st_nx        = RSC_BLK;
      push         = dec_nz;
      stall_up     = 1'b1;
    end else begin
      rn_cnt       = avail;
      rn_from_skid = !run_mode;
      rn_start     = run_mode ? '0 : idx_q;
      idx_nx       = '0;
      idx_en       = 1'b1;
      if (run_mode) begin
        st_nx = RSC_RUN;
      end else begin
        pop  = 1'b1;
        push = dec_nz;
        if (skid_level == LVL_W'(1) && !dec_nz) begin
          st_nx = RSC_RUN;
        end else begin
          st_nx    = RSC_UNB;
          stall_up = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      st_q <= RSC_RUN;
    else
      st_q <= st_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idx_q <= '0;
    else if (idx_en)
      idx_q <= idx_nx;
  end

  assign st_o = st_q;
endmodule

// File: rtl/rename_stall_ctrl_chk.sv
module rename_stall_ctrl_chk #(
  parameter int WIDTH      = 4,
  parameter int SKID_DEPTH = 4,
  parameter int CNT_W      = 3,
  parameter int LVL_W      = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] dec_cnt,
  input logic             exe_stall,
  input logic             cmt_stall,
  input logic             cmt_squash,
  input logic             cmt_rob_squash,
  input logic [CNT_W-1:0] rn_cnt,
  input logic             stall_up,
  input logic [1:0]       st_o,
  input logic [LVL_W-1:0] skid_level
);
  logic sq_any;
  assign sq_any = cmt_squash || cmt_rob_squash;

  AST_BLK_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (st_o == 2'd1) |-> (stall_up && rn_cnt == '0)); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (skid_level == LVL_W'(SKID_DEPTH) && !sq_any) |-> (dec_cnt == '0)); // R3

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_o == 2'd0 || st_o == 2'd2) && (exe_stall || cmt_stall) && !sq_any)
      |=> (st_o == 2'd1)); // R2

  AST_SQ_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    sq_any |=> (st_o == 2'd3 && skid_level == '0)); // R10

  AST_SQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_o == 2'd3 && sq_any) |-> (rn_cnt == '0 && !stall_up)); // R10

  AST_RUN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_o == 2'd0) |-> (skid_level == '0)); // R8

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rn_cnt <= CNT_W'(WIDTH)); // R6
endmodule

bind rename_stall_ctrl rename_stall_ctrl_chk #(
  .WIDTH      (WIDTH),
  .SKID_DEPTH (SKID_DEPTH),
  .CNT_W      (CNT_W),
  .LVL_W      (LVL_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .dec_cnt        (dec_cnt),
  .exe_stall      (exe_stall),
  .cmt_stall      (cmt_stall),
  .cmt_squash     (cmt_squash),
  .cmt_rob_squash (cmt_rob_squash),
  .rn_cnt         (rn_cnt),
  .stall_up       (stall_up),
  .st_o           (st_o),
  .skid_level     (skid_level)
);

// File: tb/rename_stall_ctrl_tb.sv
`timescale 1ns/1ps
module rename_stall_ctrl_tb;
  localparam int W     = 4;
  localparam int FB    = 1;
  localparam int DEPTH = 4;
  localparam int CRD   = 6;
  localparam int CW    = 3;
  localparam int LW    = 3;
  localparam int PEN   = W * FB;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] dec_cnt;
  logic          exe_stall, cmt_stall, cmt_squash, cmt_rob_squash;
  logic [CRD-1:0] rob_free, iq_free, preg_free;
  logic [CW-1:0] rn_cnt, rn_start;
  logic          rn_from_skid, stall_up;
  logic [1:0]    st_o;
  logic [LW-1:0] skid_level;

  always #5 clk = ~clk;

  rename_stall_ctrl #(
    .WIDTH (W), .FB_DELAY (FB), .SKID_DEPTH (DEPTH), .CRD_W (CRD)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .dec_cnt (dec_cnt),
    .exe_stall (exe_stall), .cmt_stall (cmt_stall),
    .cmt_squash (cmt_squash), .cmt_rob_squash (cmt_rob_squash),
    .rob_free (rob_free), .iq_free (iq_free), .preg_free (preg_free),
    .rn_cnt (rn_cnt), .rn_from_skid (rn_from_skid), .rn_start (rn_start),
    .stall_up (stall_up), .st_o (st_o), .skid_level (skid_level)
  );

  int n_chk = 0;
  int n_bad = 0;
  int hits [string];

  int m_st, m_idx;
  int m_q [$];
  int e_cnt, e_skid, e_start, e_stall, n_st, n_idx;
  bit n_push, n_pop, n_flush;
  string tag;

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic eval_model();
    int ra, ia, lim, cap, avail, dc;
    bit sqa, runm;
    dc = int'(dec_cnt);
    e_cnt = 0; e_skid = 0; e_start = 0; e_stall = 0;
    n_st = m_st; n_idx = m_idx; n_push = 0; n_pop = 0; n_flush = 0;
    tag = "R12";
    sqa = cmt_squash || cmt_rob_squash;
    ra  = int'(rob_free) - PEN;
    ia  = int'(iq_free) - PEN;
    lim = (ra < ia) ? ra : ia;
    cap = (lim <= 0) ? 0 : ((lim > W) ? W : lim);
    runm = (m_st != 2);
    if (m_st == 3 && sqa) begin
      n_flush = 1; n_idx = 0; tag = "R10";
    end else if (m_st == 1) begin
      e_stall = 1; tag = "R3";
      if (sqa) begin
        n_st = 3; n_flush = 1; n_idx = 0; tag = "R10";
      end else begin
        n_push = (dc != 0);
        if (!exe_stall && !cmt_stall && ra > 0 && ia > 0 && preg_free != 0) begin
          n_st = (m_q.size() == 0 && dc == 0) ? 0 : 2; tag = "R4";
        end
      end
    end else if (sqa) begin
      n_st = 3; n_flush = 1; n_idx = 0; tag = "R10";
    end else if (exe_stall || cmt_stall) begin
      n_st = 1; n_push = (dc != 0); e_stall = 1; tag = "R2";
    end else if (runm && dc == 0) begin
      n_st = 0; tag = (m_st == 3) ? "R11" : "R12";
    end else begin
      avail = runm ? dc : (m_q[0] - m_idx);
      if (cap == 0) begin
        n_st = 1; n_push = (dc != 0); e_stall = 1; tag = "R7";
      end else if (cap < avail) begin
        e_cnt = cap; e_skid = !runm; e_start = runm ? 0 : m_idx;
        n_idx = m_idx + cap; n_st = 1; n_push = (dc != 0); e_stall = 1;
        tag = (!runm && m_idx != 0) ? "R9" : "R6";
      end else begin
        e_cnt = avail; e_skid = !runm; e_start = runm ? 0 : m_idx; n_idx = 0;
        if (runm) begin
          n_st = 0; tag = (m_st == 3) ? "R11" : "R5";
        end else begin
          n_pop = 1; n_push = (dc != 0);
          tag = (m_idx != 0) ? "R9" : "R8";
          if (m_q.size() == 1 && dc == 0) n_st = 0;
          else begin n_st = 2; e_stall = 1; end
        end
      end
    end
  endtask

  task automatic commit_model();
    if (n_flush) m_q.delete();
    else begin
      if (n_pop) void'(m_q.pop_front());
      if (n_push) m_q.push_back(int'(dec_cnt));
    end
    m_st = n_st; m_idx = n_idx;
  endtask

  task automatic compare_all();
    chk(tag, "state", int'(st_o), m_st);
    chk(tag, "level", int'(skid_level), m_q.size());
    chk(tag, "rn_cnt", int'(rn_cnt), e_cnt);
    chk(tag, "rn_from_skid", int'(rn_from_skid), e_skid);
    chk(tag, "rn_start", int'(rn_start), e_start);
    chk(tag, "stall_up", int'(stall_up), e_stall);
    if (hits.exists(tag)) hits[tag]++; else hits[tag] = 1;
  endtask

  task automatic drive_rand(input int phase);
    int r;
    r = $urandom_range(99);
    cmt_squash     = (phase == 2) ? (r < 10) : (r < 3);
    r = $urandom_range(99);
    cmt_rob_squash = (phase == 2) ? (r < 15) : (r < 3);
    exe_stall      = ($urandom_range(99) < 12);
    cmt_stall      = ($urandom_range(99) < 8);
    if (phase == 1) begin
      rob_free = CRD'($urandom_range(7));
      iq_free  = CRD'($urandom_range(7));
    end else begin
      rob_free = CRD'($urandom_range(15));
      iq_free  = CRD'($urandom_range(15));
    end
    preg_free = CRD'($urandom_range(3));
    dec_cnt   = CW'($urandom_range(W));
    if (m_q.size() >= DEPTH) dec_cnt = '0;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    rst_n = 1'b0;
    dec_cnt = '0; exe_stall = 0; cmt_stall = 0; cmt_squash = 0; cmt_rob_squash = 0;
    rob_free = '0; iq_free = '0; preg_free = '0;
    m_st = 0; m_idx = 0; m_q.delete();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R1", "reset state", int'(st_o), 0);
      chk("R1", "reset stall", int'(stall_up), 0);
      chk("R1", "reset level", int'(skid_level), 0);
      chk("R1", "reset rn_cnt", int'(rn_cnt), 0);
    end
    hits["R1"] = 1;
    @(negedge clk); rst_n = 1'b1;
    for (int ph = 0; ph < 3; ph++) begin
      for (int c = 0; c < 6000; c++) begin
        @(negedge clk);
        drive_rand(ph);
        #1;
        eval_model();
        compare_all();
        @(posedge clk);
        commit_model();
      end
    end
    begin
      string reqs [12] = '{"R1","R2","R3","R4","R5","R6","R7","R8","R9","R10","R11","R12"};
      foreach (reqs[k]) chk(reqs[k], "cycles exercising", hits.exists(reqs[k]) ? 1 : 0, 1);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog run did not finish actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule